// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and date directly in packed BCD: seconds, minutes, hours, day of week, day of month, month (1 to 12) and a three-digit year counted from 1900. A prescaler counts reference ticks, normally from a 32768 Hz source. Each time it completes a full second, the calendar moves on by one second and rolls over through minutes, hours, days, months and years. Month lengths and the Gregorian leap-year rule are built in.

A register decoder that sits outside this block drives a field-select code, a data word and a write strobe. It also drives the run control level, which is bit 0 of its control register. Each field can be loaded from the decoder and is always visible on its own output, so a read needs no conversion. The alarm logic, which lives outside this block, receives a one-cycle pulse each time the calendar advances.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, weekday 0, day 01, month 01 and year 100 (the year 2000). `secPulse` is low.
- R2: While `rtcEn` is high, a cycle with `refTick` high counts one reference tick. Cycles with `refTick` low do not count. When `TICKS_PER_SEC` ticks have been counted, the calendar advances by one second on that clock edge. `secPulse` is high for exactly the one cycle in which the new time first appears.
- R3: On the first cycle in which `rtcEn` is seen high after being low, the prescaler restarts from zero. While `rtcEn` is low, the prescaler and every field stay frozen and `secPulse` stays low.
- R4: Seconds go from 59 to 00 and minutes go from 59 to 00, and each of these wraps advances the next field. Hours go from 23 to 00 and start a day rollover. Inside a field the ones digit carries into the tens digit (09 to 10).
- R5: At each day rollover the weekday counts up through 0 to 6, and 6 returns to 0.
- R6: At a day rollover, a day equal to the month length becomes 01 and the month advances. The month lengths are: 30 for April, June, September and November; 28 for February, or 29 in a leap year; 31 for every other month.
- R7: A year is a leap year when (year + 1900) is divisible by 4 and is either not divisible by 100 or divisible by 400. For example, 000 and 200 are not leap years, while 100, 124 and 500 are.
- R8: Month 12 rolls over to month 01 and increments the year. The year is three BCD digits: bits [7:0] hold the tens and ones digits and bits [11:8] hold the hundreds digit. 999 wraps to 000.
- R9: `wrSel` codes are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, and 7 selects no field. An 8-bit field takes `wrData[7:0]` and the year takes `wrData[11:0]`. A write while `rtcEn` is low, or with code 7, changes nothing.
- R10: When a write and a one-second advance fall on the same edge, the written field takes the written value. The other fields advance as the advance demands, with carries taken from the values held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | Reference tick qualifier, one count per high cycle |
| rtcEn | input | 1 | Run control level (control bit 0) |
| wrEn | input | 1 | Field write strobe |
| wrSel | input | 3 | Field select code |
| wrData | input | 12 | BCD write data |
| secBcd | output | 8 | Seconds, BCD 00-59 |
| minBcd | output | 8 | Minutes, BCD 00-59 |
| hourBcd | output | 8 | Hours, BCD 00-23 |
| wdayBcd | output | 8 | Day of week, 0-6 |
| mdayBcd | output | 8 | Day of month, BCD 01-31 |
| monBcd | output | 8 | Month, BCD 01-12 |
| yearBcd | output | 12 | Year offset from 1900, BCD 000-999 |
| secPulse | output | 1 | One-cycle pulse on each advance |

## Verification
The bench checks February 28 rollover for the years 2000, 1900, 2024, 2023, 2100 and 2400. A wrong century term would give the years 1900 and 2100 a February 29, or take February 29 away from 2000 and 2400. It also checks a run cut short by a disable and then resumed after the re-enable: a prescaler that is not restarted on re-enable would advance too early. It checks a write that lands on the same edge as a second wrapping from 59. A design that lets the advance win would lose the written value, and one that drops the carry would leave the minute unchanged. Finally, it checks month-end, year and 999 rollovers, and writes issued while the block is disabled or with the unused select code.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;

  localparam logic [2:0] SEL_SEC  = 3'd0;
  localparam logic [2:0] SEL_MIN  = 3'd1;
  localparam logic [2:0] SEL_HOUR = 3'd2;
  localparam logic [2:0] SEL_WDAY = 3'd3;
  localparam logic [2:0] SEL_MDAY = 3'd4;
  localparam logic [2:0] SEL_MON  = 3'd5;
  localparam logic [2:0] SEL_YEAR = 3'd6;

  localparam logic [7:0]  INIT_MDAY = 8'h01;
  localparam logic [7:0]  INIT_MON  = 8'h01;
  localparam logic [11:0] INIT_YEAR = 12'h100;

  // Strobes from control to datapath
  typedef struct packed {
    logic       advance;
    logic       load;
    logic [2:0] sel;
  } stepT;

  // Two-digit BCD increment with digit carry
  function automatic logic [7:0] bcd2Inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd2Inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd2Inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Three-digit BCD increment, 999 wraps to 000
  function automatic logic [11:0] bcd3Inc(input logic [11:0] v);
    if (v == 12'h999)          bcd3Inc = 12'h000;
    else if (v[7:0] == 8'h99)  bcd3Inc = {v[11:8] + 4'd1, 8'h00};
    else                       bcd3Inc = {v[11:8], bcd2Inc(v[7:0])};
  endfunction

  // Leap test on (offset + 1900), worked on BCD digits:
  // 1900 is a multiple of 4, so divisibility by 4 rests on 2*tens + ones;
  // a century is a multiple of 400 when the hundreds digit mod 4 is 1.
  function automatic logic leapYear(input logic [9:0] y);
    logic [4:0] low;
    low = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    leapYear = (low[1:0] == 2'b00) && ((y[7:0] != 8'h00) || (y[9:8] == 2'b01));
  endfunction

  function automatic logic [7:0] monthDays(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      monthDays = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: monthDays = 8'h30;
      default:                    monthDays = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_calendar_ctrl.sv
module bcd_calendar_ctrl
  import bcd_calendar_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       rtcEn,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  output stepT       step,
  output logic       secPulse
);

  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] tickCnt;
  logic          enPrev;
  logic          enRise;
  logic          advance;

  assign enRise  = rtcEn && !enPrev;
  assign advance = rtcEn && enPrev && refTick && (tickCnt == LAST);

  always_comb begin
    step.advance = advance;
    step.load    = wrEn && rtcEn;
    step.sel     = wrSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt  <= '0;
      enPrev   <= 1'b0;
      secPulse <= 1'b0;
    end else begin
      enPrev   <= rtcEn;
      secPulse <= advance;
      if (enRise)                tickCnt <= '0;
      else if (rtcEn && refTick) tickCnt <= (tickCnt == LAST) ? '0 : tickCnt + 1'b1;
    end
  end

endmodule

// File: rtl/bcd_calendar_dp.sv
module bcd_calendar_dp
  import bcd_calendar_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  stepT        step,
  input  logic [11:0] wrData,
  output logic [7:0]  secBcd,
  output logic [7:0]  minBcd,
  output logic [7:0]  hourBcd,
  output logic [7:0]  wdayBcd,
  output logic [7:0]  mdayBcd,
  output logic [7:0]  monBcd,
  output logic [11:0] yearBcd
);

  logic minStep, hourStep, dayStep, monStep, yearStep;
  logic [7:0] dayLimit;

  assign dayLimit = monthDays(monBcd, leapYear(yearBcd[9:0]));

  // Carry chain from values held before the edge
  always_comb begin
    minStep  = step.advance && (secBcd  >= 8'h59);
    hourStep = minStep      && (minBcd  >= 8'h59);
    dayStep  = hourStep     && (hourBcd >= 8'h23);
    monStep  = dayStep      && (mdayBcd >= dayLimit);
    yearStep = monStep      && (monBcd  >= 8'h12);
  end

  function automatic logic wrHit(input stepT s, input logic [2:0] code);
    wrHit = s.load && (s.sel == code);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secBcd  <= 8'h00;
      minBcd  <= 8'h00;
      hourBcd <= 8'h00;
      wdayBcd <= 8'h00;
      mdayBcd <= INIT_MDAY;
      monBcd  <= INIT_MON;
      yearBcd <= INIT_YEAR;
    end else begin
      if (wrHit(step, SEL_SEC))  secBcd <= wrData[7:0];
      else if (step.advance)     secBcd <= minStep ? 8'h00 : bcd2Inc(secBcd);

      if (wrHit(step, SEL_MIN))  minBcd <= wrData[7:0];
      else if (minStep)          minBcd <= hourStep ? 8'h00 : bcd2Inc(minBcd);

      if (wrHit(step, SEL_HOUR)) hourBcd <= wrData[7:0];
      else if (hourStep)         hourBcd <= dayStep ? 8'h00 : bcd2Inc(hourBcd);

      if (wrHit(step, SEL_WDAY)) wdayBcd <= wrData[7:0];
      else if (dayStep)          wdayBcd <= (wdayBcd >= 8'h06) ? 8'h00 : wdayBcd + 8'h01;

      if (wrHit(step, SEL_MDAY)) mdayBcd <= wrData[7:0];
      else if (dayStep)          mdayBcd <= monStep ? 8'h01 : bcd2Inc(mdayBcd);

      if (wrHit(step, SEL_MON))  monBcd <= wrData[7:0];
      else if (monStep)          monBcd <= yearStep ? 8'h01 : bcd2Inc(monBcd);

      if (wrHit(step, SEL_YEAR)) yearBcd <= wrData;
      else if (yearStep)         yearBcd <= bcd3Inc(yearBcd);
    end
  end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_calendar_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refTick,
  input  logic        rtcEn,
  input  logic        wrEn,
  input  logic [2:0]  wrSel,
  input  logic [11:0] wrData,
  output logic [7:0]  secBcd,
  output logic [7:0]  minBcd,
  output logic [7:0]  hourBcd,
  output logic [7:0]  wdayBcd,
  output logic [7:0]  mdayBcd,
  output logic [7:0]  monBcd,
  output logic [11:0] yearBcd,
  output logic        secPulse
);

  stepT step;

  bcd_calendar_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) ctrl_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .rtcEn(rtcEn),
    .wrEn(wrEn), .wrSel(wrSel), .step(step), .secPulse(secPulse)
  );

  bcd_calendar_dp dp_i (
    .clk(clk), .rstN(rstN), .step(step), .wrData(wrData),
    .secBcd(secBcd), .minBcd(minBcd), .hourBcd(hourBcd), .wdayBcd(wdayBcd),
    .mdayBcd(mdayBcd), .monBcd(monBcd), .yearBcd(yearBcd)
  );

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rtcEn,
  input logic        wrEn,
  input logic [7:0]  secBcd,
  input logic [7:0]  minBcd,
  input logic [7:0]  hourBcd,
  input logic [7:0]  wdayBcd,
  input logic [7:0]  mdayBcd,
  input logic [7:0]  monBcd,
  input logic [11:0] yearBcd,
  input logic        secPulse
);

  assert_frozen_when_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rtcEn |=> $stable({secBcd, minBcd, hourBcd, wdayBcd, mdayBcd, monBcd, yearBcd}));

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |=> !secPulse);

  assert_pulse_needs_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |-> $past(rtcEn));

  assert_sec_moves_R4: assert property (@(posedge clk) disable iff (!rstN)
    (secPulse && $past(!(wrEn && rtcEn))) |-> (secBcd != $past(secBcd)));

  assert_mday_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    (secPulse && $past(!(wrEn && rtcEn)) && (monBcd != $past(monBcd))) |-> (mdayBcd == 8'h01));

endmodule

bind bcd_calendar bcd_calendar_chk chk_i (
  .clk(clk), .rstN(rstN), .rtcEn(rtcEn), .wrEn(wrEn),
  .secBcd(secBcd), .minBcd(minBcd), .hourBcd(hourBcd), .wdayBcd(wdayBcd),
  .mdayBcd(mdayBcd), .monBcd(monBcd), .yearBcd(yearBcd), .secPulse(secPulse)
);

// File: tb/bcd_calendar_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_tb_top;

  localparam int TPS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b0;
  logic rtcEn = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrSel = 3'd7;
  logic [11:0] wrData = 12'h000;
  logic [7:0] secBcd, minBcd, hourBcd, wdayBcd, mdayBcd, monBcd;
  logic [11:0] yearBcd;
  logic secPulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_calendar #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .rtcEn(rtcEn),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .secBcd(secBcd), .minBcd(minBcd), .hourBcd(hourBcd), .wdayBcd(wdayBcd),
    .mdayBcd(mdayBcd), .monBcd(monBcd), .yearBcd(yearBcd), .secPulse(secPulse)
  );

  task automatic chk(input string req, input string what, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chkTime(input string req, input logic [7:0] s, input logic [7:0] m,
                         input logic [7:0] h, input logic [7:0] w, input logic [7:0] d,
                         input logic [7:0] mo, input logic [11:0] y);
    chk(req, "sec", {4'h0, secBcd}, {4'h0, s});
    chk(req, "min", {4'h0, minBcd}, {4'h0, m});
    chk(req, "hour", {4'h0, hourBcd}, {4'h0, h});
    chk(req, "wday", {4'h0, wdayBcd}, {4'h0, w});
    chk(req, "mday", {4'h0, mdayBcd}, {4'h0, d});
    chk(req, "mon", {4'h0, monBcd}, {4'h0, mo});
    chk(req, "year", yearBcd, y);
  endtask

  task automatic writeField(input logic [2:0] sel, input logic [11:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 3'd7;
  endtask

  task automatic setTime(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                         input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                         input logic [11:0] y);
    writeField(3'd0, {4'h0, s});
    writeField(3'd1, {4'h0, m});
    writeField(3'd2, {4'h0, h});
    writeField(3'd3, {4'h0, w});
    writeField(3'd4, {4'h0, d});
    writeField(3'd5, {4'h0, mo});
    writeField(3'd6, y);
  endtask

  // n reference ticks, results visible at return
  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      refTick = 1'b1;
    end
    @(negedge clk);
    refTick = 1'b0;
  endtask

  task automatic stepSecond();
    pulses(TPS);
  endtask

  task automatic testReset();
    chkTime("R1", 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h100);
    chk("R1", "secPulse", {11'h0, secPulse}, 12'h000);
  endtask

  task automatic testDisabled();
    writeField(3'd0, 12'h033);
    chk("R9", "write while disabled", {4'h0, secBcd}, 12'h000);
    pulses(2 * TPS);
    chk("R3", "no count while disabled", {4'h0, secBcd}, 12'h000);
    chk("R3", "no pulse while disabled", {11'h0, secPulse}, 12'h000);
    @(negedge clk);
    rtcEn = 1'b1;
    @(negedge clk);
  endtask

  task automatic testCarryAndWday();
    setTime(8'h58, 8'h59, 8'h23, 8'h06, 8'h28, 8'h02, 12'h100);
    stepSecond();
    chk("R2", "sec after one second", {4'h0, secBcd}, 12'h059);
    chk("R2", "pulse with update", {11'h0, secPulse}, 12'h001);
    @(negedge clk);
    chk("R2", "pulse one cycle", {11'h0, secPulse}, 12'h000);
    stepSecond();
    chkTime("R4 R5", 8'h00, 8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 12'h100);
    setTime(8'h09, 8'h19, 8'h10, 8'h02, 8'h05, 8'h07, 12'h123);
    stepSecond();
    chk("R4", "ones to tens digit", {4'h0, secBcd}, 12'h010);
    writeField(3'd0, 12'h059);
    stepSecond();
    chkTime("R4", 8'h00, 8'h20, 8'h10, 8'h02, 8'h05, 8'h07, 12'h123);
    chk("R5", "no wday change mid-day", {4'h0, wdayBcd}, 12'h002);
  endtask

  task automatic testGating();
    writeField(3'd0, 12'h020);
    repeat (6) @(negedge clk);
    chk("R2", "refTick low holds", {4'h0, secBcd}, 12'h020);
    pulses(2);
    @(negedge clk);
    rtcEn = 1'b0; refTick = 1'b1;
    repeat (3) @(negedge clk);
    refTick = 1'b0;
    chk("R3", "halted", {4'h0, secBcd}, 12'h020);
    rtcEn = 1'b1;
    @(negedge clk);
    pulses(TPS - 1);
    chk("R3", "reload on enable", {4'h0, secBcd}, 12'h020);
    pulses(1);
    chk("R3", "second after reload", {4'h0, secBcd}, 12'h021);
  endtask

  task automatic febCase(input logic [11:0] y, input logic leap);
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, y);
    stepSecond();
    chk("R7", "leap mday", {4'h0, mdayBcd}, leap ? 12'h029 : 12'h001);
    chk("R7", "leap mon", {4'h0, monBcd}, leap ? 12'h002 : 12'h003);
  endtask

  task automatic testMonths();
    setTime(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 12'h124);
    stepSecond();
    chk("R6", "30-day month end mday", {4'h0, mdayBcd}, 12'h001);
    chk("R6", "30-day month end mon", {4'h0, monBcd}, 12'h005);
    setTime(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h01, 12'h124);
    stepSecond();
    chk("R6", "31-day month day 31", {4'h0, mdayBcd}, 12'h031);
    chk("R6", "31-day month mon", {4'h0, monBcd}, 12'h001);
    stepSecond();
    stepSecond();
    chk("R6", "31-day month no early roll", {4'h0, mdayBcd}, 12'h031);
  endtask

  task automatic testYears();
    setTime(8'h59, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 12'h199);
    stepSecond();
    chkTime("R8", 8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h01, 12'h200);
    setTime(8'h59, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 12'h999);
    stepSecond();
    chk("R8", "999 wraps", yearBcd, 12'h000);
    setTime(8'h59, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 12'h109);
    stepSecond();
    chk("R8", "ones to tens carry", yearBcd, 12'h110);
  endtask

  task automatic testWriteWins();
    setTime(8'h59, 8'h10, 8'h08, 8'h02, 8'h11, 8'h06, 12'h124);
    pulses(TPS - 1);
    chk("R10", "before edge", {4'h0, secBcd}, 12'h059);
    @(negedge clk);
    refTick = 1'b1; wrEn = 1'b1; wrSel = 3'd0; wrData = 12'h015;
    @(negedge clk);
    refTick = 1'b0; wrEn = 1'b0; wrSel = 3'd7;
    chk("R10", "written sec kept", {4'h0, secBcd}, 12'h015);
    chk("R10", "min still carried", {4'h0, minBcd}, 12'h011);
    chk("R10", "pulse on collision", {11'h0, secPulse}, 12'h001);
  endtask

  task automatic testBadSel();
    writeField(3'd7, 12'h777);
    chkTime("R9", 8'h15, 8'h11, 8'h08, 8'h02, 8'h11, 8'h06, 12'h124);
    writeField(3'd6, 12'h321);
    chk("R9", "year takes 12 bits", yearBcd, 12'h321);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabled();
    testCarryAndWday();
    testGating();
    febCase(12'h100, 1'b1);
    febCase(12'h000, 1'b0);
    febCase(12'h124, 1'b1);
    febCase(12'h123, 1'b0);
    febCase(12'h200, 1'b0);
    febCase(12'h500, 1'b1);
    testMonths();
    testYears();
    testWriteWins();
    testBadSel();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule